// File: doc/BRIEF.md
# Burst-of-Four Separate-Port SRAM

This block is an on-chip memory with two independent ports, one for reads and one for writes. Each port takes a burst index. The index selects a group of four consecutive words. A port's own counter supplies the two word-offset bits, so every transfer moves exactly four words. Double-data-rate transfer is modelled as two words per core clock, carried as a lower beat and an upper beat. A burst therefore spans two clocks.

A write request captures the burst index. In each of the next two cycles, the block takes one beat pair from the write port. Each beat has its own byte enables, sampled with that beat's data. The write data is held in a one-cycle staging register before it reaches the array. A read request returns its four words two clocks later, as two beat pairs, each marked by a valid strobe. When a read fetches a word that is still in the staging register, the staged bytes are merged over the array contents lane by lane. The read therefore always sees the newest data.

A port accepts a request at most every second cycle. A request that arrives in the cycle right after an accepted request on the same port is dropped. In that cycle the port raises a busy flag. After reset both ports are idle and the array contents are undefined.

Top module: `qb4_sram`

## Requirements
- R1: A write request accepted in cycle n takes beat pair 0 in cycle n+1 and beat pair 1 in cycle n+2, four words in total.
- R2: The word address is burst_index*4 + offset. Beat pair k carries offset 2k on the lower beat and offset 2k+1 on the upper beat, so the offsets run 0, 1, 2, 3.
- R3: Byte-enable bit i of a beat covers data bits [i*BYTE_W +: BYTE_W] of that beat. A lane whose enable is 0 keeps its old contents. Write-port data presented in a cycle with no pending write beat is ignored.
- R4: A read request accepted in cycle n drives rd_valid_o high in cycle n+2 (offsets 0 and 1) and in cycle n+3 (offsets 2 and 3). rd_valid_o is low in every other cycle.
- R5: The read port and the write port work at the same time. Requests on both ports in the same cycle are both accepted.
- R6: Beat pair k of a read accepted in cycle n is fetched in cycle n+1+k. It reflects every write beat presented in an earlier cycle, byte-merged, whether or not that beat has reached the array.
- R7: A request in the cycle right after an accepted request on the same port is ignored, and that port's busy flag is high in that cycle only. A request two cycles after an accepted one is accepted.
- R8: During and right after reset, rd_valid_o, rd_busy_o and wr_busy_o are low.
- R9: Read requests issued every second cycle produce an unbroken run of rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write burst request |
| wr_addr_i | input | ADDR_W | Write burst index |
| wr_lo_data_i | input | DATA_W | Lower write beat |
| wr_hi_data_i | input | DATA_W | Upper write beat |
| wr_lo_be_i | input | DATA_W/BYTE_W | Byte enables for the lower beat |
| wr_hi_be_i | input | DATA_W/BYTE_W | Byte enables for the upper beat |
| wr_busy_o | output | 1 | Write request dropped this cycle |
| rd_req_i | input | 1 | Read burst request |
| rd_addr_i | input | ADDR_W | Read burst index |
| rd_busy_o | output | 1 | Read request dropped this cycle |
| rd_valid_o | output | 1 | Read beat pair valid |
| rd_lo_data_o | output | DATA_W | Lower read beat |
| rd_hi_data_o | output | DATA_W | Upper read beat |

## Verification
The assertions check the burst sequencing on every cycle:
- a pair-1 phase always follows a pair-0 phase;
- a busy flag only follows an accepted request;
- every accepted read yields a valid strobe two cycles later;
- a valid run never ends after a single cycle.

Some behaviour can only be shown by the bench, because it needs a reference copy of the memory:
- whether the data is correct;
- the word order within a burst;
- the effect of each byte enable;
- whether a read issued right behind a write returns the staged bytes.

The bench scenarios check these against a model updated beat by beat.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PAIR0 = 2'd1,
    PH_PAIR1 = 2'd2
  } burst_ph_e;
endpackage

// File: rtl/qb4_burst_ctl.sv
module qb4_burst_ctl
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              act_o,
  output logic              pair_o,
  output logic [ADDR_W-1:0] idx_o
);
  burst_ph_e         ph_q, ph_d;
  logic [ADDR_W-1:0] idx_q;
  logic              accept;

  assign accept = req_i && (ph_q != PH_PAIR0);
  assign busy_o = req_i && (ph_q == PH_PAIR0);

  always_comb begin
    if (accept)                ph_d = PH_PAIR0;
    else if (ph_q == PH_PAIR0) ph_d = PH_PAIR1;
    else                       ph_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) idx_q <= addr_i;
    end
  end

  assign act_o  = (ph_q != PH_IDLE);
  assign pair_o = (ph_q == PH_PAIR1);
  assign idx_o  = idx_q;

  AST_PAIR1_AFTER_PAIR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_PAIR1) |-> ($past(ph_q) == PH_PAIR0)); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $past(req_i)); // R7
endmodule

// File: rtl/qb4_byte_merge.sv
module qb4_byte_merge #(
  parameter int DATA_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic [DATA_W-1:0]        old_i,
  input  logic [DATA_W-1:0]        new_i,
  input  logic [DATA_W/BYTE_W-1:0] en_i,
  output logic [DATA_W-1:0]        out_o
);
  localparam int LANES = DATA_W / BYTE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_o[l*BYTE_W +: BYTE_W] = en_i[l] ? new_i[l*BYTE_W +: BYTE_W]
                                               : old_i[l*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/qb4_array.sv
module qb4_array #(
  parameter int DATA_W = 18,
  parameter int BYTE_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                             clk_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                wr_idx_i,
  input  logic                             wr_pair_i,
  input  logic [1:0][DATA_W-1:0]           wr_data_i,
  input  logic [1:0][DATA_W/BYTE_W-1:0]    wr_be_i,
  input  logic [ADDR_W-1:0]                rd_idx_i,
  input  logic                             rd_pair_i,
  output logic [1:0][DATA_W-1:0]           rd_data_o
);
  localparam int WA    = ADDR_W + 2;
  localparam int WORDS = 4 << ADDR_W;

  logic [DATA_W-1:0]      mem_q [WORDS];
  logic [1:0][DATA_W-1:0] old_w, new_w;

  for (genvar b = 0; b < 2; b++) begin : g_beat
    assign old_w[b]     = mem_q[{wr_idx_i, wr_pair_i, 1'(b)}];
    assign rd_data_o[b] = mem_q[{rd_idx_i, rd_pair_i, 1'(b)}];
    qb4_byte_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wmerge (
      .old_i(old_w[b]), .new_i(wr_data_i[b]), .en_i(wr_be_i[b]), .out_o(new_w[b])
    );
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < 2; b++) begin
        mem_q[WA'({wr_idx_i, wr_pair_i, 1'(b)})] <= new_w[b];
      end
    end
  end
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram #(
  parameter int DATA_W = 18,
  parameter int BYTE_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_req_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_lo_data_i,
  input  logic [DATA_W-1:0]        wr_hi_data_i,
  input  logic [DATA_W/BYTE_W-1:0] wr_lo_be_i,
  input  logic [DATA_W/BYTE_W-1:0] wr_hi_be_i,
  output logic                     wr_busy_o,
  input  logic                     rd_req_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic                     rd_busy_o,
  output logic                     rd_valid_o,
  output logic [DATA_W-1:0]        rd_lo_data_o,
  output logic [DATA_W-1:0]        rd_hi_data_o
);
  localparam int LANES = DATA_W / BYTE_W;

  logic              wr_act, wr_pair, rd_act, rd_pair;
  logic [ADDR_W-1:0] wr_idx, rd_idx;

  qb4_burst_ctl #(.ADDR_W(ADDR_W)) u_wr_ctl (
    .clk_i, .rst_ni, .req_i(wr_req_i), .addr_i(wr_addr_i), .busy_o(wr_busy_o),
    .act_o(wr_act), .pair_o(wr_pair), .idx_o(wr_idx)
  );
  qb4_burst_ctl #(.ADDR_W(ADDR_W)) u_rd_ctl (
    .clk_i, .rst_ni, .req_i(rd_req_i), .addr_i(rd_addr_i), .busy_o(rd_busy_o),
    .act_o(rd_act), .pair_o(rd_pair), .idx_o(rd_idx)
  );

  // one-cycle staging of each write beat pair before the array
  logic                        hold_v_q, hold_pair_q;
  logic [ADDR_W-1:0]           hold_idx_q;
  logic [1:0][DATA_W-1:0]      hold_data_q;
  logic [1:0][LANES-1:0]       hold_be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_pair_q <= 1'b0;
      hold_idx_q  <= '0;
      hold_data_q <= '0;
      hold_be_q   <= '0;
    end else begin
      hold_v_q <= wr_act;
      if (wr_act) begin
        hold_pair_q <= wr_pair;
        hold_idx_q  <= wr_idx;
        hold_data_q <= {wr_hi_data_i, wr_lo_data_i};
        hold_be_q   <= {wr_hi_be_i, wr_lo_be_i};
      end
    end
  end

  logic [1:0][DATA_W-1:0] arr_rd, fwd_rd;
  logic                   fwd_hit;

  qb4_array #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i, .we_i(hold_v_q), .wr_idx_i(hold_idx_q), .wr_pair_i(hold_pair_q),
    .wr_data_i(hold_data_q), .wr_be_i(hold_be_q),
    .rd_idx_i(rd_idx), .rd_pair_i(rd_pair), .rd_data_o(arr_rd)
  );

  assign fwd_hit = hold_v_q && (hold_idx_q == rd_idx) && (hold_pair_q == rd_pair);

  for (genvar b = 0; b < 2; b++) begin : g_fwd
    qb4_byte_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_fmerge (
      .old_i(arr_rd[b]), .new_i(hold_data_q[b]),
      .en_i(fwd_hit ? hold_be_q[b] : '0), .out_o(fwd_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_lo_data_o <= '0;
      rd_hi_data_o <= '0;
    end else begin
      rd_valid_o <= rd_act;
      if (rd_act) begin
        rd_lo_data_o <= fwd_rd[0];
        rd_hi_data_o <= fwd_rd[1];
      end
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_busy_o) |=> ##1 rd_valid_o); // R4
  AST_RD_PAIR_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |=> rd_valid_o); // R4
  AST_WR_BUSY_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_o |-> $past(wr_req_i && !wr_busy_o)); // R7
  AST_RD_BUSY_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_busy_o |-> $past(rd_req_i && !rd_busy_o)); // R7
endmodule

// File: tb/sim_qb4_sram.sv
module sim_qb4_sram;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam int AW = 4;
  localparam int LN = DW / BW;
  localparam int WORDS = 4 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_req_i = 1'b0, rd_req_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [DW-1:0] wr_lo_data_i = '0, wr_hi_data_i = '0;
  logic [LN-1:0] wr_lo_be_i = '0, wr_hi_be_i = '0;
  logic          wr_busy_o, rd_busy_o, rd_valid_o;
  logic [DW-1:0] rd_lo_data_o, rd_hi_data_o;

  qb4_sram #(.DATA_W(DW), .BYTE_W(BW), .ADDR_W(AW)) u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] mem_m [WORDS];
  int w_ph = 0, r_ph = 0, w_idx_m = 0, r_idx_m = 0;
  bit exp_v [8];
  logic [DW-1:0] exp_lo [8], exp_hi [8];
  bit be_full = 1'b1;
  string tag_s = "R1", tag_v = "R4";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                        input logic [LN-1:0] be);
    logic [DW-1:0] r = o;
    for (int l = 0; l < LN; l++) if (be[l]) r[l*BW +: BW] = n[l*BW +: BW];
    return r;
  endfunction

  task automatic step(input bit wreq, input int waddr, input bit rreq, input int raddr);
    int slot = cyc % 8;
    bit w_acc, r_acc;
    chk(rd_valid_o == exp_v[slot], tag_v, "rd_valid", 32'(rd_valid_o), 32'(exp_v[slot]));
    if (exp_v[slot]) begin
      chk(rd_lo_data_o == exp_lo[slot], tag_s, "rd_lo", 32'(rd_lo_data_o), 32'(exp_lo[slot]));
      chk(rd_hi_data_o == exp_hi[slot], tag_s, "rd_hi", 32'(rd_hi_data_o), 32'(exp_hi[slot]));
    end
    exp_v[slot] = 1'b0;
    wr_req_i = wreq; wr_addr_i = AW'(waddr);
    rd_req_i = rreq; rd_addr_i = AW'(raddr);
    wr_lo_data_i = DW'($urandom); wr_hi_data_i = DW'($urandom);
    wr_lo_be_i = be_full ? '1 : LN'($urandom);
    wr_hi_be_i = be_full ? '1 : LN'($urandom);
    #1;
    chk(wr_busy_o == (wreq && w_ph == 1), "R7", "wr_busy", 32'(wr_busy_o), 32'(wreq && w_ph == 1));
    chk(rd_busy_o == (rreq && r_ph == 1), "R7", "rd_busy", 32'(rd_busy_o), 32'(rreq && r_ph == 1));
    // fetch sees only beats presented in earlier cycles (R6)
    if (r_ph != 0) begin
      int base = r_idx_m * 4 + (r_ph - 1) * 2;
      exp_v[(cyc+1)%8]  = 1'b1;
      exp_lo[(cyc+1)%8] = mem_m[base];
      exp_hi[(cyc+1)%8] = mem_m[base+1];
    end
    if (w_ph != 0) begin
      int base = w_idx_m * 4 + (w_ph - 1) * 2;
      mem_m[base]   = mrg(mem_m[base], wr_lo_data_i, wr_lo_be_i);
      mem_m[base+1] = mrg(mem_m[base+1], wr_hi_data_i, wr_hi_be_i);
    end
    w_acc = wreq && w_ph != 1;
    r_acc = rreq && r_ph != 1;
    w_ph = w_acc ? 1 : (w_ph == 1 ? 2 : 0);
    r_ph = r_acc ? 1 : (r_ph == 1 ? 2 : 0);
    if (w_acc) w_idx_m = waddr;
    if (r_acc) r_idx_m = raddr;
    cyc++;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) exp_v[i] = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!rd_valid_o && !rd_busy_o && !wr_busy_o, "R8", "reset outputs",
        {29'd0, rd_valid_o, rd_busy_o, wr_busy_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rd_valid_o, "R8", "valid after reset", 32'(rd_valid_o), 32'd0);
    // R1: fill every burst back to back
    tag_s = "R1";
    for (int i = 0; i < (1 << AW); i++) begin step(1, i, 0, 0); step(0, 0, 0, 0); end
    idle(3);
    // R2/R9: read all bursts every second cycle, word order checked
    tag_s = "R2"; tag_v = "R9";
    for (int i = 0; i < (1 << AW); i++) begin step(0, 0, 1, i); step(0, 0, 0, 0); end
    idle(4);
    tag_v = "R4";
    // R3: partial byte enables, junk data while idle
    tag_s = "R3"; be_full = 1'b0;
    step(1, 3, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0); idle(3);
    step(0, 0, 1, 3); idle(4);
    // R6: read right behind write (forwarded from staging)
    tag_s = "R6";
    step(1, 7, 0, 0); step(0, 0, 1, 7); idle(5);
    step(1, 9, 0, 0); step(0, 0, 0, 0); step(0, 0, 1, 9); idle(5);
    step(1, 9, 1, 9); idle(5);
    // R7/R5: dropped requests and simultaneous ports
    tag_s = "R5";
    step(1, 2, 1, 4); step(1, 5, 1, 6); step(1, 6, 1, 2); step(1, 1, 1, 1); idle(5);
    // random traffic
    tag_s = "R6";
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) != 0, int'($urandom % (1 << AW)),
           ($urandom % 3) != 0, int'($urandom % (1 << AW)));
    idle(6);
    finish_run();
  end
endmodule